// File: doc/BRIEF.md
# Call Transfer Pointer Update

This block commits the architectural side effects of a control-transfer instruction once its operand access has finished. It holds the procedure pointer (current ring, current segment, instruction counter and a privileged-mode flag) and a small file of pointer registers, each with a ring, a segment number, a word number and a bit number. When a completion strobe arrives with a transfer, transfer-and-save or call class, the block loads the new procedure pointer. For transfer-and-save it also saves a return pointer into a register that the opcode selects. For a call it also builds a fresh stack pointer in the highest register.

Plain operand reads, and cycles without the strobe, leave every register untouched. All updates take effect on one rising clock edge. A combinational read port exposes any pointer register, so the surrounding logic can observe the file.

Top module: `ptr_commit_unit`

## Requirements
- R1: A synchronous active-high reset clears every pointer register (ring, segment, word, bit) and the whole procedure pointer (ring, segment, counter, privileged flag) to zero.
- R2: When `done` is low, or `op_class` is 2'b00 (plain read), no pointer register and no procedure pointer field changes at the next edge.
- R3: With `done` high and `op_class` 2'b01 (transfer), the next edge loads the procedure segment from `eff_seg` and the counter from `eff_addr`. The procedure ring and the pointer registers keep their values.
- R4: For op_class 2'b01, 2'b10 and 2'b11, the privileged flag becomes `desc_priv` when `eff_ring` is 0, and is cleared for any other ring.
- R5: With `op_class` 2'b10 (transfer-and-save), the destination register index is `opcode[1:0]` when `opcode` is at most octal 273. Otherwise it is `opcode[1:0]` + 4.
- R6: The saved register receives the old procedure ring as its ring and the old counter plus one, wrapped to 18 bits, as its word number. Its bit number is 0. The procedure segment and counter update as in R3, and no other register changes.
- R7: The saved register's segment takes the old procedure segment only when `append_mode` is high. Otherwise it keeps its previous segment.
- R8: With `op_class` 2'b11 (call), register 7's segment becomes register 6's segment when `eff_ring` equals the old procedure ring. Otherwise it becomes `{stack_base, eff_ring}`, which is the stack base shifted left by 3 and ORed with the ring.
- R9: On a call, register 7's ring becomes `eff_ring`, and its word and bit numbers become 0.
- R10: On a call, the procedure ring, segment and counter become `eff_ring`, `eff_seg` and `eff_addr`.
- R11: `rd_ring`, `rd_seg`, `rd_word` and `rd_bit` show, without a clock delay, the register selected by `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| done | input | 1 | Operand access complete, commit strobe |
| op_class | input | 2 | 00 read, 01 transfer, 10 transfer-and-save, 11 call |
| opcode | input | 9 | Instruction opcode |
| eff_ring | input | 3 | Effective ring of the access |
| eff_seg | input | 15 | Target segment number |
| eff_addr | input | 18 | Computed address |
| stack_base | input | 12 | Stack base field |
| desc_priv | input | 1 | Privilege bit from the segment descriptor |
| append_mode | input | 1 | Segmented addressing mode active |
| rd_idx | input | 3 | Pointer register to read |
| proc_ring | output | 3 | Procedure ring |
| proc_seg | output | 15 | Procedure segment |
| proc_ctr | output | 18 | Instruction counter |
| proc_priv | output | 1 | Privileged flag |
| rd_ring | output | 3 | Selected register ring |
| rd_seg | output | 15 | Selected register segment |
| rd_word | output | 18 | Selected register word number |
| rd_bit | output | 6 | Selected register bit number |

## Verification
Some rules are checked by assertions on every cycle:
- a plain read or a missing strobe holds the procedure pointer;
- every committing class loads the target segment and counter;
- a transfer keeps the ring, and a call takes the effective ring;
- privilege is never left set outside ring 0;
- a register that is not addressed by a write stays stable;
- the save index decode agrees with the octal 273 split.

The bench's scenarios alone show the values written into the file:
- the return word and its wrap at the 18-bit limit;
- a segment kept when append mode is off;
- the choice between copying register 6 and building the stack segment;
- the reset contents seen through the read port.

// File: rtl/ptr_commit_pkg.sv
package ptr_commit_pkg;
  localparam int RING_W   = 3;
  localparam int SEG_W    = 15;
  localparam int WORD_W   = 18;
  localparam int BIT_W    = 6;
  localparam int OPC_W    = 9;
  localparam int PR_NUM   = 8;
  localparam int IDX_W    = $clog2(PR_NUM);
  localparam int STK_W    = SEG_W - RING_W;
  localparam int HALF_NUM = PR_NUM / 2;
  localparam logic [OPC_W-1:0] SAVE_SPLIT = 9'o273;

  typedef logic [RING_W-1:0] ring_t;
  typedef logic [SEG_W-1:0]  seg_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [BIT_W-1:0]  bitno_t;
  typedef logic [IDX_W-1:0]  idx_t;

  typedef enum logic [1:0] {
    CLS_READ = 2'b00,
    CLS_XFER = 2'b01,
    CLS_SAVE = 2'b10,
    CLS_CALL = 2'b11
  } op_class_e;

  typedef struct packed {
    ring_t  ring;
    seg_t   seg;
    word_t  word;
    bitno_t bitno;
  } ptr_t;

  // Destination register of a transfer-and-save.
  function automatic idx_t save_index(input logic [OPC_W-1:0] opc);
    idx_t base;
    base = idx_t'(opc[1:0]);
    if (opc > SAVE_SPLIT) base = base + idx_t'(HALF_NUM);
    return base;
  endfunction

  // Return word number: counter advanced by one, wrapping.
  function automatic word_t next_word(input word_t ctr);
    return ctr + word_t'(1);
  endfunction

  // Stack segment built from the base field and the target ring.
  function automatic seg_t stack_seg(input logic [STK_W-1:0] stk, input ring_t ring);
    return (seg_t'(stk) << RING_W) | seg_t'(ring);
  endfunction

  // Privilege is only granted in ring zero.
  function automatic logic priv_grant(input ring_t ring, input logic bit_in);
    return (ring == '0) && bit_in;
  endfunction
endpackage

// File: rtl/ptr_save_decode.sv
module ptr_save_decode
  import ptr_commit_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  ring_t            proc_ring,
  input  seg_t             proc_seg,
  input  word_t            proc_ctr,
  input  logic             append_mode,
  output idx_t             save_idx,
  output ptr_t             save_ptr,
  output logic             save_seg_en
);
  assign save_idx           = save_index(opcode);
  assign save_ptr.ring      = proc_ring;
  assign save_ptr.seg       = proc_seg;
  assign save_ptr.word      = next_word(proc_ctr);
  assign save_ptr.bitno     = '0;
  assign save_seg_en        = append_mode;

  always_comb begin
    // R5
    save_bank_chk: assert ((int'(save_idx) < HALF_NUM) == (opcode <= SAVE_SPLIT));
    // R5
    save_low_chk: assert (save_idx[1:0] == opcode[1:0]);
  end
endmodule

// File: rtl/ptr_call_frame.sv
module ptr_call_frame
  import ptr_commit_pkg::*;
(
  input  ring_t            eff_ring,
  input  ring_t            proc_ring,
  input  seg_t             src_seg,
  input  logic [STK_W-1:0] stack_base,
  output ptr_t             frame_ptr,
  output logic             same_ring
);
  assign same_ring       = (eff_ring == proc_ring);
  assign frame_ptr.ring  = eff_ring;
  assign frame_ptr.seg   = same_ring ? src_seg : stack_seg(stack_base, eff_ring);
  assign frame_ptr.word  = '0;
  assign frame_ptr.bitno = '0;
endmodule

// File: rtl/ptr_regfile.sv
module ptr_regfile
  import ptr_commit_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  idx_t widx,
  input  ptr_t wdata,
  input  logic wseg_en,
  input  idx_t ridx,
  output ptr_t rdata,
  output seg_t src_seg
);
  localparam idx_t SRC_REG = idx_t'(PR_NUM - 2);

  ptr_t regs [PR_NUM];

  always_ff @(posedge clk) begin
    for (int k = 0; k < PR_NUM; k++) begin
      if (rst) begin
        regs[k] <= '0;
      end else if (we && (widx == idx_t'(k))) begin
        regs[k].ring  <= wdata.ring;
        regs[k].word  <= wdata.word;
        regs[k].bitno <= wdata.bitno;
        if (wseg_en) regs[k].seg <= wdata.seg;
      end
    end
  end

  assign rdata   = regs[ridx];
  assign src_seg = regs[SRC_REG].seg;

  for (genvar g = 0; g < PR_NUM; g++) begin : g_hold
    // R6
    untouched_reg_chk: assert property (@(posedge clk) disable iff (rst)
      !(we && (widx == idx_t'(g))) |=> $stable(regs[g]));
  end
endmodule

// File: rtl/ptr_commit_unit.sv
module ptr_commit_unit
  import ptr_commit_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [1:0]        op_class,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [RING_W-1:0] eff_ring,
  input  logic [SEG_W-1:0]  eff_seg,
  input  logic [WORD_W-1:0] eff_addr,
  input  logic [STK_W-1:0]  stack_base,
  input  logic              desc_priv,
  input  logic              append_mode,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [RING_W-1:0] proc_ring,
  output logic [SEG_W-1:0]  proc_seg,
  output logic [WORD_W-1:0] proc_ctr,
  output logic              proc_priv,
  output logic [RING_W-1:0] rd_ring,
  output logic [SEG_W-1:0]  rd_seg,
  output logic [WORD_W-1:0] rd_word,
  output logic [BIT_W-1:0]  rd_bit
);
  localparam idx_t CALL_REG = idx_t'(PR_NUM - 1);

  op_class_e cls;
  assign cls = op_class_e'(op_class);

  logic is_call, is_save, commit, pr_write;
  assign is_call  = (cls == CLS_CALL);
  assign is_save  = (cls == CLS_SAVE);
  assign commit   = done && (cls != CLS_READ);
  assign pr_write = done && (is_call || is_save);

  idx_t save_idx;
  ptr_t save_ptr, frame_ptr, rdata;
  logic save_seg_en, same_ring;
  seg_t src_seg;

  ptr_save_decode i_save (
    .opcode(opcode), .proc_ring(proc_ring), .proc_seg(proc_seg),
    .proc_ctr(proc_ctr), .append_mode(append_mode),
    .save_idx(save_idx), .save_ptr(save_ptr), .save_seg_en(save_seg_en)
  );

  ptr_call_frame i_frame (
    .eff_ring(eff_ring), .proc_ring(proc_ring), .src_seg(src_seg),
    .stack_base(stack_base), .frame_ptr(frame_ptr), .same_ring(same_ring)
  );

  idx_t wr_idx;
  ptr_t wr_data;
  logic wr_seg_en;
  assign wr_idx    = is_call ? CALL_REG : save_idx;
  assign wr_data   = is_call ? frame_ptr : save_ptr;
  assign wr_seg_en = is_call | save_seg_en;

  ptr_regfile i_file (
    .clk(clk), .rst(rst), .we(pr_write), .widx(wr_idx), .wdata(wr_data),
    .wseg_en(wr_seg_en), .ridx(rd_idx), .rdata(rdata), .src_seg(src_seg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      proc_ring <= '0;
      proc_seg  <= '0;
      proc_ctr  <= '0;
      proc_priv <= 1'b0;
    end else if (commit) begin
      proc_seg  <= eff_seg;
      proc_ctr  <= eff_addr;
      proc_priv <= priv_grant(eff_ring, desc_priv);
      if (is_call) proc_ring <= eff_ring;
    end
  end

  assign rd_ring = rdata.ring;
  assign rd_seg  = rdata.seg;
  assign rd_word = rdata.word;
  assign rd_bit  = rdata.bitno;

  // R2
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!done || op_class == 2'b00) |=> $stable({proc_ring, proc_seg, proc_ctr, proc_priv}));
  // R3
  target_load_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_class != 2'b00) |=> (proc_seg == $past(eff_seg)) && (proc_ctr == $past(eff_addr)));
  // R4
  ring_priv_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_class != 2'b00 && eff_ring != 3'd0) |=> !proc_priv);
  // R10
  call_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (done && op_class == 2'b11) |=> proc_ring == $past(eff_ring));
  // R3
  xfer_ring_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (op_class == 2'b01 || op_class == 2'b10)) |=> $stable(proc_ring));
endmodule

// File: tb/test_ptr_commit_unit.sv
`timescale 1ns/1ps
module test_ptr_commit_unit;
  logic clk = 1'b0;
  logic rst, done, desc_priv, append_mode;
  logic [1:0] op_class;
  logic [8:0] opcode;
  logic [2:0] eff_ring, rd_idx;
  logic [14:0] eff_seg;
  logic [17:0] eff_addr;
  logic [11:0] stack_base;
  logic [2:0] proc_ring, rd_ring;
  logic [14:0] proc_seg, rd_seg;
  logic [17:0] proc_ctr, rd_word;
  logic proc_priv;
  logic [5:0] rd_bit;

  always #2 clk = ~clk;

  ptr_commit_unit i_ptr_commit_unit (
    .clk(clk), .rst(rst), .done(done), .op_class(op_class), .opcode(opcode),
    .eff_ring(eff_ring), .eff_seg(eff_seg), .eff_addr(eff_addr),
    .stack_base(stack_base), .desc_priv(desc_priv), .append_mode(append_mode),
    .rd_idx(rd_idx), .proc_ring(proc_ring), .proc_seg(proc_seg),
    .proc_ctr(proc_ctr), .proc_priv(proc_priv), .rd_ring(rd_ring),
    .rd_seg(rd_seg), .rd_word(rd_word), .rd_bit(rd_bit)
  );

  typedef struct packed {
    logic [1:0]  cls;
    logic [8:0]  opc;
    logic [2:0]  er;
    logic [14:0] es;
    logic [17:0] ea;
    logic [11:0] stk;
    logic        pv;
    logic        ap;
    logic [2:0]  chk;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 9'o000, 3'd4, 15'o01234, 18'o000100, 12'o0012, 1'b1, 1'b1, 3'd7},
    '{2'd2, 9'o271, 3'd4, 15'o00055, 18'o000777, 12'o0000, 1'b0, 1'b1, 3'd1},
    '{2'd2, 9'o274, 3'd5, 15'o00066, 18'o777777, 12'o0000, 1'b0, 1'b0, 3'd4},
    '{2'd2, 9'o273, 3'd0, 15'o00077, 18'o000010, 12'o0000, 1'b1, 1'b1, 3'd3},
    '{2'd1, 9'o000, 3'd2, 15'o00100, 18'o000020, 12'o0000, 1'b1, 1'b1, 3'd3},
    '{2'd0, 9'o555, 3'd6, 15'o07777, 18'o123456, 12'o7777, 1'b1, 1'b1, 3'd7},
    '{2'd2, 9'o276, 3'd1, 15'o00200, 18'o000030, 12'o0000, 1'b0, 1'b1, 3'd6},
    '{2'd3, 9'o000, 3'd4, 15'o00300, 18'o000040, 12'o0055, 1'b0, 1'b1, 3'd7},
    '{2'd3, 9'o000, 3'd0, 15'o00400, 18'o000050, 12'o7777, 1'b1, 1'b1, 3'd7},
    '{2'd2, 9'o677, 3'd0, 15'o00500, 18'o000060, 12'o0000, 1'b0, 1'b1, 3'd7}
  };

  int n_checks = 0;
  int n_fail = 0;

  logic [2:0]  m_ring [8];
  logic [14:0] m_seg  [8];
  logic [17:0] m_word [8];
  logic [5:0]  m_bit  [8];
  logic [2:0]  p_ring;
  logic [14:0] p_seg;
  logic [17:0] p_ctr;
  logic        p_priv;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 8; k++) begin
      m_ring[k] = 0; m_seg[k] = 0; m_word[k] = 0; m_bit[k] = 0;
    end
    p_ring = 0; p_seg = 0; p_ctr = 0; p_priv = 0;
  endtask

  task automatic model_commit(input vec_t v);
    int n;
    if (v.cls == 2'd2) begin
      n = (v.opc <= 9'o273) ? int'(v.opc % 4) : int'(v.opc % 4) + 4;
      m_ring[n] = p_ring;
      m_word[n] = p_ctr + 18'd1;
      m_bit[n]  = 0;
      if (v.ap) m_seg[n] = p_seg;
    end
    if (v.cls == 2'd3) begin
      m_seg[7]  = (v.er == p_ring) ? m_seg[6] : {v.stk, v.er};
      m_ring[7] = v.er;
      m_word[7] = 0;
      m_bit[7]  = 0;
      p_ring    = v.er;
    end
    if (v.cls != 2'd0) begin
      p_seg  = v.es;
      p_ctr  = v.ea;
      p_priv = (v.er == 3'd0) ? v.pv : 1'b0;
    end
  endtask

  task automatic drive(input vec_t v, input logic strobe);
    @(negedge clk);
    op_class = v.cls; opcode = v.opc; eff_ring = v.er; eff_seg = v.es;
    eff_addr = v.ea; stack_base = v.stk; desc_priv = v.pv; append_mode = v.ap;
    done = strobe;
    @(posedge clk);
    @(negedge clk);
    done = 1'b0;
    #1;
  endtask

  task automatic check_proc(input string req);
    check(req, {proc_ring, proc_seg, proc_ctr, proc_priv}, {p_ring, p_seg, p_ctr, p_priv});
  endtask

  task automatic check_reg(input string req, input int k);
    rd_idx = 3'(k);
    #1;
    check(req, {rd_ring, rd_seg, rd_word, rd_bit}, {m_ring[k], m_seg[k], m_word[k], m_bit[k]});
  endtask

  function automatic string proc_tag(input logic [1:0] c);
    case (c)
      2'd0: return "R2 proc hold";
      2'd1: return "R3 R4 transfer";
      2'd2: return "R6 R4 save proc";
      default: return "R10 R4 call proc";
    endcase
  endfunction

  function automatic string reg_tag(input logic [1:0] c);
    case (c)
      2'd2: return "R5 R6 R7 saved reg";
      2'd3: return "R8 R9 call frame";
      default: return "R2 R3 reg untouched";
    endcase
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; done = 1'b0; op_class = 0; opcode = 0; eff_ring = 0; eff_seg = 0;
    eff_addr = 0; stack_base = 0; desc_priv = 0; append_mode = 0; rd_idx = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset contents
    check_proc("R1 reset proc");
    for (int k = 0; k < 8; k++) check_reg("R1 reset reg", k);

    // R2: strobe low with a call class changes nothing
    drive('{2'd3, 9'o0, 3'd5, 15'o11111, 18'o22222, 12'o333, 1'b1, 1'b1, 3'd7}, 1'b0);
    check_proc("R2 no strobe proc");
    check_reg("R2 no strobe reg", 7);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      model_commit(VECS[i]);
      check_proc(proc_tag(VECS[i].cls));
      check_reg(reg_tag(VECS[i].cls), int'(VECS[i].chk));
    end

    // R11: read port across the whole file
    for (int k = 0; k < 8; k++) check_reg("R11 read port", k);

    // R1: reset in the middle of a run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    #1;
    check_proc("R1 rerun reset proc");
    check_reg("R1 rerun reset reg", 7);
    check_reg("R1 rerun reset reg", 6);

    finish_run();
  end
endmodule